// File: doc/BRIEF.md
# Value-Deduplicating Cache Data Store

This block is the data array of a small cache. It keeps each distinct wide data word only once. Every word slot of every line holds a short field. For a wide word the field is an index into a shared table of unique values. A word small enough to fit in the field is held in the field itself, and a flag bit tells the two cases apart. Tag lookup, miss handling, refill and victim choice belong to the surrounding cache and are not part of this block.

On a write of a wide word, every live table entry is compared with the word in the same cycle. If one matches, the slot shares that entry. If none matches, the slot claims an entry whose reference count is zero. Each entry keeps a count of the slots that point to it. The overwritten slot gives up its old reference in the same update, and an entry whose count drops to zero is free again. If a wide word needs a new entry and none is free, the write is refused and the slot keeps its old contents. A read rebuilds the word from the field, either by sign-extending the inlined value or by fetching the table entry.

Top module: `dd_cache_store`

## Requirements
- R1: After reset, and after a reset applied in the middle of operation, every slot reads as zero and `tbl_full` is 0.
- R2: A word whose bits from bit 7 upward are all equal (signed range -128 to 127 with the default parameters) is inlined in the slot. It never takes a table entry, is never refused, and reads back sign-extended to 32 bits, even while the table is full.
- R3: Slots that hold the same wide word share one table entry. Writing a word that is already stored takes no new entry, so it is accepted even while the table is full.
- R4: An entry stays in use while any slot points to it. It becomes free in the cycle after its last referencing slot is overwritten.
- R5: A wide word that matches no live entry, written while no entry is free, is refused. `wr_reject` is 1 in that cycle and the slot keeps its previous value. A slot's own old entry does not count as free during the write that overwrites it.
- R6: `tbl_full` is 1 exactly when all 8 table entries are referenced by at least one slot.
- R7: A write takes effect at the clock edge. A read of the same slot in the next cycle returns the written word, and reads are combinational.
- R8: Rewriting a slot with the word it already holds is accepted and leaves the table occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_line | input | 2 | Line index of the write |
| wr_word | input | 2 | Word offset of the write |
| wr_data | input | 32 | Word to store |
| rd_line | input | 2 | Line index of the read |
| rd_word | input | 2 | Word offset of the read |
| rd_data | output | 32 | Rebuilt word of the addressed slot |
| tbl_full | output | 1 | No value-table entry is free |
| wr_reject | output | 1 | The current write is refused for lack of an entry |

## Verification
Releasing the old reference of a slot and taking a new reference fall into the same write cycle, and both can land on the same table entry. The bench provokes this by rewriting a slot with its current wide word while the table is full, and expects the write to be accepted with `tbl_full` still set. It also overwrites a slot that is the sole owner of its entry with a new wide word while full, and expects a refusal with the old word still readable. Entries whose last reference is dropped are judged by `tbl_full` falling and by a later new word being stored.

// File: rtl/dd_pkg.sv
// Shared types of the value-deduplicating data store.
// Assumes nothing beyond standard SystemVerilog.
package dd_pkg;
    // Outcome of a write request, decided combinationally.
    typedef enum logic [2:0] {
        WA_IDLE,
        WA_INLINE,
        WA_SHARE,
        WA_ALLOC,
        WA_REJECT
    } dd_wact_e;
endpackage

// File: rtl/dd_narrow_chk.sv
// Decides whether a word fits a signed field of NARROW_W bits.
// Assumes NARROW_W < DATA_W.
module dd_narrow_chk #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic              narrow
);
    localparam int TOP_W = DATA_W - NARROW_W + 1;

    logic [TOP_W-1:0] top_bits;

    // Narrow when the sign bit and every bit above it agree.
    always_comb begin
        top_bits = data[DATA_W-1:NARROW_W-1];
        narrow   = (&top_bits) | ~(|top_bits);
    end
endmodule

// File: rtl/dd_value_search.sv
// Parallel search of the value table: the lowest live entry equal to the
// key, and the lowest free entry. Assumes DEPTH is a power of two.
module dd_value_search #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic [DATA_W-1:0] vals [DEPTH],
    input  logic [DEPTH-1:0]  live,
    input  logic [DATA_W-1:0] key,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              free_any,
    output logic [IDX_W-1:0]  free_idx
);
    logic [DEPTH-1:0] eq;

    // One comparator per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = live[g] && (vals[g] == key);
    end

    // Priority encoders, lowest index wins.
    always_comb begin
        hit      = |eq;
        free_any = ~&live;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
            if (!live[i]) free_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dd_value_table.sv
// Storage of unique wide values with one reference counter each.
// Increment and decrement may hit the same entry in one cycle.
// Assumes the caller never decrements a zero counter.
module dd_value_table #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 5,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic [IDX_W-1:0]  inc_idx,
    input  logic              dec_en,
    input  logic [IDX_W-1:0]  dec_idx,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] vals [DEPTH],
    output logic [CNT_W-1:0]  cnts [DEPTH],
    output logic [DEPTH-1:0]  live
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic up, down;

        assign up      = inc_en && (inc_idx == IDX_W'(g));
        assign down    = dec_en && (dec_idx == IDX_W'(g));
        assign live[g] = (cnts[g] != '0);

        // Counter update: net change of one increment and one decrement.
        always_ff @(posedge clk) begin
            if (!rst_n) cnts[g] <= '0;
            else        cnts[g] <= cnts[g] + CNT_W'(up) - CNT_W'(down);
        end

        // Value load on allocation; the load always comes with an increment.
        always_ff @(posedge clk) begin
            if (!rst_n)              vals[g] <= '0;
            else if (load_en && up)  vals[g] <= load_data;
        end
    end
endmodule

// File: rtl/dd_cache_store.sv
// Data array of a small cache with value deduplication. Each slot holds a
// field of FIELD_W bits: the top bit set means the lower bits are an
// inlined signed value, clear means they carry a table index.
// Assumes LINES, WORDS and VT_DEPTH are powers of two, at least 2, and
// that the index fits in FIELD_W-1 bits.
module dd_cache_store #(
    parameter int LINES    = 4,
    parameter int WORDS    = 4,
    parameter int DATA_W   = 32,
    parameter int VT_DEPTH = 8,
    parameter int FIELD_W  = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(LINES)-1:0]  wr_line,
    input  logic [$clog2(WORDS)-1:0]  wr_word,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(LINES)-1:0]  rd_line,
    input  logic [$clog2(WORDS)-1:0]  rd_word,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      tbl_full,
    output logic                      wr_reject
);
    import dd_pkg::*;

    localparam int SLOTS  = LINES * WORDS;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int PAY_W  = FIELD_W - 1;
    localparam int IDX_W  = $clog2(VT_DEPTH);
    localparam int CNT_W  = $clog2(SLOTS + 1);

    logic [FIELD_W-1:0] slot_q [SLOTS];
    logic [DATA_W-1:0]  vt_vals [VT_DEPTH];
    logic [CNT_W-1:0]   vt_cnts [VT_DEPTH];
    logic [VT_DEPTH-1:0] vt_live;

    logic [SLOT_W-1:0]  wslot, rslot;
    logic [FIELD_W-1:0] old_f, new_f, rd_f;
    logic               narrow, hit, free_any;
    logic [IDX_W-1:0]   hit_idx, free_idx, use_idx;
    dd_wact_e           act;

    assign wslot = {wr_line, wr_word};
    assign rslot = {rd_line, rd_word};
    assign old_f = slot_q[wslot];

    dd_narrow_chk #(.DATA_W(DATA_W), .NARROW_W(PAY_W)) u_narrow (
        .data   (wr_data),
        .narrow (narrow)
    );

    dd_value_search #(.DATA_W(DATA_W), .DEPTH(VT_DEPTH), .IDX_W(IDX_W)) u_search (
        .vals     (vt_vals),
        .live     (vt_live),
        .key      (wr_data),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    // Classify the write and build the new slot field.
    always_comb begin
        act     = WA_IDLE;
        use_idx = hit ? hit_idx : free_idx;
        new_f   = '0;
        if (wr_en) begin
            if (narrow)        act = WA_INLINE;
            else if (hit)      act = WA_SHARE;
            else if (free_any) act = WA_ALLOC;
            else               act = WA_REJECT;
        end
        if (act == WA_INLINE) begin
            new_f = {1'b1, wr_data[PAY_W-1:0]};
        end else begin
            new_f[IDX_W-1:0] = use_idx;
        end
    end

    logic commit, drop_old, take_new;
    assign commit   = (act == WA_INLINE) || (act == WA_SHARE) || (act == WA_ALLOC);
    assign drop_old = commit && !old_f[FIELD_W-1];
    assign take_new = (act == WA_SHARE) || (act == WA_ALLOC);

    dd_value_table #(.DATA_W(DATA_W), .DEPTH(VT_DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (take_new),
        .inc_idx   (use_idx),
        .dec_en    (drop_old),
        .dec_idx   (IDX_W'(old_f[PAY_W-1:0])),
        .load_en   (act == WA_ALLOC),
        .load_data (wr_data),
        .vals      (vt_vals),
        .cnts      (vt_cnts),
        .live      (vt_live)
    );

    // Pointer array: reset to inlined zero, updated on committed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) slot_q[s] <= {1'b1, {PAY_W{1'b0}}};
        end else if (commit) begin
            slot_q[wslot] <= new_f;
        end
    end

    // Read path: sign-extend an inlined field or fetch the table entry.
    always_comb begin
        rd_f = slot_q[rslot];
        if (rd_f[FIELD_W-1]) rd_data = {{(DATA_W-PAY_W){rd_f[PAY_W-1]}}, rd_f[PAY_W-1:0]};
        else                 rd_data = vt_vals[IDX_W'(rd_f[PAY_W-1:0])];
    end

    assign tbl_full  = !free_any;
    assign wr_reject = (act == WA_REJECT);
endmodule

// File: rtl/dd_cache_store_chk.sv
// Property checker for dd_cache_store, attached by bind below.
// Assumes the top parameters are passed through unchanged.
module dd_cache_store_chk #(
    parameter int LINES    = 4,
    parameter int WORDS    = 4,
    parameter int DATA_W   = 32,
    parameter int VT_DEPTH = 8,
    parameter int FIELD_W  = 9,
    parameter int CNT_W    = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [$clog2(LINES)-1:0] wr_line,
    input logic [$clog2(WORDS)-1:0] wr_word,
    input logic [DATA_W-1:0]        wr_data,
    input logic [$clog2(LINES)-1:0] rd_line,
    input logic [$clog2(WORDS)-1:0] rd_word,
    input logic [DATA_W-1:0]        rd_data,
    input logic                     tbl_full,
    input logic                     wr_reject,
    input logic [FIELD_W-1:0]       slot_q [LINES*WORDS],
    input logic [DATA_W-1:0]        vt_vals [VT_DEPTH],
    input logic [CNT_W-1:0]         vt_cnts [VT_DEPTH]
);
    localparam int SLOTS = LINES * WORDS;
    localparam int PAY_W = FIELD_W - 1;

    logic [SLOTS*FIELD_W-1:0] slot_flat;
    logic                     small_word;
    int                       ref_total, cnt_total;
    logic                     dup_found;

    // Derived views of the state for the properties.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) slot_flat[s*FIELD_W +: FIELD_W] = slot_q[s];
        small_word = (wr_data == {{(DATA_W-PAY_W){wr_data[PAY_W-1]}}, wr_data[PAY_W-1:0]});
        ref_total = 0;
        for (int s = 0; s < SLOTS; s++) if (!slot_q[s][FIELD_W-1]) ref_total++;
        cnt_total = 0;
        for (int e = 0; e < VT_DEPTH; e++) cnt_total += int'(vt_cnts[e]);
        dup_found = 1'b0;
        for (int a = 0; a < VT_DEPTH; a++)
            for (int b = a + 1; b < VT_DEPTH; b++)
                if (vt_cnts[a] != '0 && vt_cnts[b] != '0 && vt_vals[a] == vt_vals[b])
                    dup_found = 1'b1;
    end

    AST_REJECT_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> tbl_full); // R5
    AST_REJECT_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |=> $stable(slot_flat)); // R5
    AST_NARROW_NEVER_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && small_word) |-> !wr_reject); // R2
    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_reject) |=> (({rd_line, rd_word} != $past({wr_line, wr_word}))
                                   || (rd_data == $past(wr_data)))); // R7
    AST_COUNTS_MATCH_REFS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_total == cnt_total); // R4
    AST_NO_DUPLICATE_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_found); // R3
endmodule

bind dd_cache_store dd_cache_store_chk #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W),
    .VT_DEPTH(VT_DEPTH), .FIELD_W(FIELD_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_line(wr_line),
    .wr_word(wr_word), .wr_data(wr_data), .rd_line(rd_line),
    .rd_word(rd_word), .rd_data(rd_data), .tbl_full(tbl_full),
    .wr_reject(wr_reject), .slot_q(slot_q), .vt_vals(vt_vals),
    .vt_cnts(vt_cnts)
);

// File: tb/sim_dd_cache_store.sv
// Self-checking bench for dd_cache_store with default parameters.
module sim_dd_cache_store;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int VEC_SLOT [NVEC] = '{0, 1, 2, 3, 4, 5, 6, 7};
    localparam logic [31:0] VEC_DATA [NVEC] = '{
        32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_007F, 32'hFFFF_FF80,
        32'h0000_0080, 32'hFFFF_FF7F, 32'h0000_0080, 32'hDEAD_BEEF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_line = '0, wr_word = '0, rd_line = '0, rd_word = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tbl_full, wr_reject;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic rej;

    dd_cache_store u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_line(wr_line),
        .wr_word(wr_word), .wr_data(wr_data), .rd_line(rd_line),
        .rd_word(rd_word), .rd_data(rd_data), .tbl_full(tbl_full),
        .wr_reject(wr_reject));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write; captures the refusal flag in the write cycle.
    task automatic wr(input int slot, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_line = 2'(slot >> 2); wr_word = 2'(slot & 3); wr_data = d;
        #1 rej = wr_reject;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input int slot, output logic [31:0] d);
        rd_line = 2'(slot >> 2); rd_word = 2'(slot & 3);
        #1 d = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic check_all_zero(input string req);
        logic [31:0] d;
        for (int s = 0; s < 16; s++) begin
            rd(s, d);
            chk(req, d, 32'h0);
        end
        chk(req, {31'b0, tbl_full}, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        do_reset();
        check_all_zero("R1 reset");

        // Vector walk: write then read back next cycle.
        for (int v = 0; v < NVEC; v++) begin
            wr(VEC_SLOT[v], VEC_DATA[v]);
            chk(v < 4 ? "R2 inline accept" : "R7 accept", {31'b0, rej}, 32'h0);
            rd(VEC_SLOT[v], d);
            chk(v < 4 ? "R2 sign-extended read" : "R7 read after write", d, VEC_DATA[v]);
        end
        chk("R6 three entries used", {31'b0, tbl_full}, 32'h0);

        // Shared word across five slots uses one entry.
        for (int s = 8; s <= 12; s++) wr(s, 32'h1234_5678);
        rd(8, d);  chk("R3 shared read", d, 32'h1234_5678);
        rd(12, d); chk("R3 shared read", d, 32'h1234_5678);
        chk("R3 one entry for shared", {31'b0, tbl_full}, 32'h0);

        wr(13, 32'hA000_0001);
        wr(14, 32'hA000_0002);
        wr(15, 32'hA000_0003);
        chk("R6 seven used not full", {31'b0, tbl_full}, 32'h0);
        wr(0, 32'hA000_0004);
        chk("R6 eight used full", {31'b0, tbl_full}, 32'h1);

        // Refusal of a new wide word while full.
        wr(1, 32'hCAFE_0000);
        chk("R5 reject flag", {31'b0, rej}, 32'h1);
        rd(1, d); chk("R5 slot unchanged", d, 32'hFFFF_FFFF);

        wr(1, 32'h0000_0080);
        chk("R3 existing word accepted when full", {31'b0, rej}, 32'h0);
        rd(1, d); chk("R3 existing word read", d, 32'h0000_0080);

        wr(2, 32'hFFFF_FFFB);
        chk("R2 narrow accepted when full", {31'b0, rej}, 32'h0);
        rd(2, d); chk("R2 narrow read when full", d, 32'hFFFF_FFFB);

        wr(13, 32'hA000_0001);
        chk("R8 same word accepted", {31'b0, rej}, 32'h0);
        chk("R8 occupancy unchanged", {31'b0, tbl_full}, 32'h1);
        rd(13, d); chk("R8 read", d, 32'hA000_0001);

        wr(13, 32'hCAFE_0000);
        chk("R5 own entry not free", {31'b0, rej}, 32'h1);
        rd(13, d); chk("R5 sole owner unchanged", d, 32'hA000_0001);

        // Releasing the last reference frees an entry.
        wr(7, 32'h0);
        chk("R4 entry freed", {31'b0, tbl_full}, 32'h0);
        wr(7, 32'hCAFE_0000);
        chk("R4 freed entry reused", {31'b0, rej}, 32'h0);
        rd(7, d); chk("R4 new word read", d, 32'hCAFE_0000);
        chk("R6 full again", {31'b0, tbl_full}, 32'h1);

        for (int s = 8; s <= 11; s++) wr(s, 32'h1);
        chk("R4 shared still referenced", {31'b0, tbl_full}, 32'h1);
        rd(12, d); chk("R4 last sharer intact", d, 32'h1234_5678);
        wr(12, 32'h1);
        chk("R4 shared entry freed", {31'b0, tbl_full}, 32'h0);

        do_reset();
        check_all_zero("R1 mid-run reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule